// File: doc/BRIEF.md
# Pipelined 32-bit Posit Multiplier

This block multiplies two 32-bit posit numbers whose exponent field is fixed at two bits and returns the product as a 32-bit posit, rounded to the nearest representable value with ties going to the even pattern. A new operand pair can be presented on every clock cycle together with a valid strobe. The product leaves the block exactly four cycles later with its own valid strobe, so the unit streams at full rate with no back-pressure.

Inside, both operands are taken apart at the same time into a signed scale and a significand with a hidden leading one. Negative operands are first made positive by two's complement. The scales are added while the significands are multiplied. The product is normalised and its scale is split into a regime run and a 2-bit exponent. The regime, exponent and fraction are packed into one bit stream, and the bits beyond the 31 that fit are reduced to a guard bit and a sticky bit. The last stage rounds, saturates and applies the sign. Zero (all bits clear) and NaR (only the top bit set) bypass the arithmetic.

Top module: `posit32_mul_pipe`

## Requirements
- R1: Every input with `in_valid` high produces exactly one output with `out_valid` high four rising edges later. `out_valid` at any edge equals `in_valid` from four edges earlier, and operands may arrive on consecutive cycles.
- R2: If either operand is NaR (0x80000000), the result is NaR (0x80000000).
- R3: If either operand is zero (0x00000000) and neither is NaR, the result is zero (0x00000000).
- R4: A negative posit is the two's complement of its positive pattern. For nonzero, non-NaR operands, the result's top bit equals the XOR of the operand top bits, and negating one operand negates the result pattern.
- R5: Products that are exactly representable come out exactly. Examples: 1.0 (0x40000000) squared is 1.0, 2.0 (0x48000000) times 3.0 (0x4C000000) is 6.0 (0x54000000), and 4.0 (0x50000000) squared is 16.0 (0x60000000).
- R6: An inexact result is rounded to the nearest posit. When the exact value lies exactly halfway between two posits, the pattern whose least significant bit is 0 is chosen.
- R7: A product whose magnitude is at or above the largest posit (0x7FFFFFFF, which is 2^120) gives that largest posit with the product's sign. It never gives NaR.
- R8: A nonzero product whose magnitude is at or below the smallest positive posit (0x00000001, which is 2^-120) gives that smallest posit with the product's sign. A product of two nonzero, non-NaR operands is never zero and never NaR.
- R9: Operands with the longest possible regime runs decode correctly. For example, 0x7FFFFFFF times 0x00000001 is exactly 1.0 (0x40000000).
- R10: While `rst_n` is low at a rising edge, the next state has `out_valid` low and `out_p` zero, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | High when `in_a` and `in_b` carry an operand pair |
| in_a | input | 32 | First operand, posit with a 2-bit exponent field |
| in_b | input | 32 | Second operand, posit with a 2-bit exponent field |
| out_valid | output | 1 | High when `out_p` carries a product |
| out_p | output | 32 | Rounded posit product |

## Verification
The embedded properties check on every cycle the relations that need no arithmetic model. These are the four-cycle valid alignment, NaR and zero dominance, the sign of the product, and the rule that a product of two ordinary numbers never collapses to zero or NaR. The bit-exact value of a product can only be shown by the bench's scenarios. Those scenarios cover exact products, halfway cases that must round up or down to the even pattern, saturation at both ends of the range, operands with maximal regime runs, and a back-to-back stream with gaps. The stream uses operands biased towards long regime runs and is compared with an independent bit-serial reference.

// File: rtl/posit_mul_pkg.sv
// Package shared by the posit multiplier pipeline.
// Holds the fixed exponent-field width and the operand class type.
// Assumes the exponent field width never changes with posit size.
package posit_mul_pkg;

    localparam int ES = 2;

    typedef enum logic [1:0] {
        CLS_NUM  = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_NAR  = 2'd2
    } pclass_e;

    // NaR dominates zero, and zero dominates an ordinary number.
    function automatic pclass_e merge_class(input pclass_e a, input pclass_e b);
        if (a == CLS_NAR || b == CLS_NAR)
            return CLS_NAR;
        else if (a == CLS_ZERO || b == CLS_ZERO)
            return CLS_ZERO;
        else
            return CLS_NUM;
    endfunction

endpackage

// File: rtl/posit_decode.sv
// Combinational decoder: posit pattern -> class, sign, scale, significand.
// Makes negative inputs positive by two's complement, then measures the regime run.
// Assumes the regime holds at least two bits, which is true for every nonzero pattern.
// Scale and significand are don't-care when the class is zero or NaR.
module posit_decode
    import posit_mul_pkg::*;
#(
    parameter int N   = 32,
    parameter int SCW = 9,
    parameter int SW  = 28
) (
    input  logic [N-1:0]           p,
    output pclass_e                cls,
    output logic                   sgn,
    output logic signed [SCW-1:0]  scale,
    output logic [SW-1:0]          sig
);
    localparam int BW = N - 1;
    localparam int FW = BW - 2 - ES;
    localparam int RW = $clog2(N) + 1;

    logic [BW-1:0]         body;
    logic [RW-1:0]         run;
    logic [BW-3:0]         tail;
    logic [ES-1:0]         expo;
    logic signed [SCW-1:0] kval;

    // Classify the pattern and form the magnitude bits below the sign.
    always_comb begin : classify
        sgn  = p[N-1];
        body = p[N-1] ? (~p[N-2:0] + 1'b1) : p[N-2:0];
        if (p[N-2:0] == '0)
            cls = p[N-1] ? CLS_NAR : CLS_ZERO;
        else
            cls = CLS_NUM;
    end

    // Count the run of bits equal to the first bit after the sign.
    always_comb begin : count_run
        logic stop;
        stop = 1'b0;
        run  = '0;
        for (int i = BW - 1; i >= 0; i--) begin
            if (!stop && (body[i] == body[BW-1]))
                run = run + 1'b1;
            else
                stop = 1'b1;
        end
    end

    // Drop the regime and its terminator, then read the exponent and fraction.
    always_comb begin : extract_fields
        tail  = body[BW-3:0] << (run - 1'b1);
        expo  = tail[BW-3 -: ES];
        sig   = {1'b1, tail[FW-1:0]};
        kval  = body[BW-1] ? (SCW'(run) - SCW'(1)) : -SCW'(run);
        scale = (kval <<< ES) + SCW'(expo);
    end

endmodule

// File: rtl/posit_encode.sv
// Combinational encoder: scale and raw significand product -> truncated posit body.
// Normalises the product and builds the regime, exponent and fraction as one bit stream.
// Reduces every bit below the last kept bit to a guard bit and a sticky bit.
// Flags scales outside the range of the regime so that a later stage can saturate.
// Assumes the product has its leading one in one of its top two bits.
module posit_encode
    import posit_mul_pkg::*;
#(
    parameter int N   = 32,
    parameter int SCW = 9,
    parameter int PW  = 56
) (
    input  logic signed [SCW-1:0] scale,
    input  logic [PW-1:0]         prod,
    output logic [N-2:0]          body,
    output logic                  guard,
    output logic                  sticky,
    output logic                  sat_hi,
    output logic                  sat_lo
);
    localparam int FRW = PW - 1;
    localparam int TW  = N + ES + PW;

    logic signed [SCW-1:0] sc;
    logic signed [SCW-1:0] k;
    logic [SCW-1:0]        rlen;
    logic [FRW-1:0]        frac;
    logic [ES-1:0]         expo;
    logic [TW-1:0]         field;
    logic [TW-1:0]         mask;
    logic [TW-1:0]         vec;

    // Normalise the significand product so that its leading one is implicit.
    always_comb begin : normalise
        if (prod[PW-1]) begin
            sc   = scale + SCW'(1);
            frac = prod[PW-2:0];
        end else begin
            sc   = scale;
            frac = {prod[PW-3:0], 1'b0};
        end
    end

    // Split the scale into regime value and exponent; find the regime length.
    always_comb begin : split_scale
        k      = sc >>> ES;
        expo   = sc[ES-1:0];
        rlen   = k[SCW-1] ? (SCW'(1) - k) : (k + SCW'(2));
        sat_hi = (k >= $signed(SCW'(N - 2)));
        sat_lo = (k <= -$signed(SCW'(N - 1)));
    end

    // Place the exponent and fraction behind the regime and cut at the posit width.
    always_comb begin : pack_stream
        field = {expo, frac, {(TW - ES - FRW){1'b0}}} >> rlen;
        if (k[SCW-1])
            mask = {{(TW - 1){1'b0}}, 1'b1} << (TW - int'(rlen));
        else
            mask = ~({TW{1'b1}} >> (rlen - SCW'(1)));
        vec    = field | mask;
        body   = vec[TW-1 -: N-1];
        guard  = vec[TW-N];
        sticky = |vec[TW-N-1:0];
    end

endmodule

// File: rtl/posit_round.sv
// Combinational final stage: rounding, saturation, specials and sign.
// Rounds the truncated body to nearest with ties to even.
// Assumes the body never has all bits set unless it is saturated, so rounding cannot wrap.
module posit_round
    import posit_mul_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-2:0] body,
    input  logic         guard,
    input  logic         sticky,
    input  logic         sat_hi,
    input  logic         sat_lo,
    input  pclass_e      cls,
    input  logic         sgn,
    output logic [N-1:0] result
);
    logic [N-2:0] mag;
    logic         bump;

    // Pick the magnitude: a saturated bound or the rounded body.
    always_comb begin : pick_magnitude
        bump = guard & (body[0] | sticky);
        if (sat_hi)
            mag = '1;
        else if (sat_lo)
            mag = {{(N - 2){1'b0}}, 1'b1};
        else
            mag = body + {{(N - 2){1'b0}}, bump};
    end

    // Apply the special classes and the sign.
    always_comb begin : apply_sign
        if (cls == CLS_NAR)
            result = {1'b1, {(N - 1){1'b0}}};
        else if (cls == CLS_ZERO)
            result = '0;
        else if (sgn)
            result = -{1'b0, mag};
        else
            result = {1'b0, mag};
    end

endmodule

// File: rtl/posit32_mul_pipe.sv
// Four-stage posit multiplier, default size 32 bits, exponent field of two bits.
// Stage 1 decodes both operands. Stage 2 adds the scales and multiplies the significands.
// Stage 3 encodes the product. Stage 4 rounds and applies the sign.
// Takes one operand pair per cycle; valid travels alongside the data with no stall.
module posit32_mul_pipe
    import posit_mul_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] in_a,
    input  logic [N-1:0] in_b,
    output logic         out_valid,
    output logic [N-1:0] out_p
);
    localparam int FW  = N - 3 - ES;
    localparam int SW  = FW + 1;
    localparam int PW  = 2 * SW;
    localparam int SCW = $clog2(4 * N) + 2;
    localparam int NOP = 2;

    logic [N-1:0]          d_in    [NOP];
    pclass_e               d_cls   [NOP];
    logic                  d_sgn   [NOP];
    logic signed [SCW-1:0] d_scale [NOP];
    logic [SW-1:0]         d_sig   [NOP];

    assign d_in[0] = in_a;
    assign d_in[1] = in_b;

    for (genvar g = 0; g < NOP; g++) begin : g_dec
        posit_decode #(.N(N), .SCW(SCW), .SW(SW)) u_dec (
            .p     (d_in[g]),
            .cls   (d_cls[g]),
            .sgn   (d_sgn[g]),
            .scale (d_scale[g]),
            .sig   (d_sig[g])
        );
    end

    // Stage 1 registers: decoded operands.
    logic                  s1_v;
    pclass_e               s1_cls;
    logic                  s1_sgn;
    logic signed [SCW-1:0] s1_sc  [NOP];
    logic [SW-1:0]         s1_sig [NOP];

    // Capture both decoded operands and their combined class and sign.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_cls <= CLS_ZERO;
            s1_sgn <= 1'b0;
            for (int i = 0; i < NOP; i++) begin
                s1_sc[i]  <= '0;
                s1_sig[i] <= '0;
            end
        end else begin
            s1_v   <= in_valid;
            s1_cls <= merge_class(d_cls[0], d_cls[1]);
            s1_sgn <= d_sgn[0] ^ d_sgn[1];
            for (int i = 0; i < NOP; i++) begin
                s1_sc[i]  <= d_scale[i];
                s1_sig[i] <= d_sig[i];
            end
        end
    end

    // Stage 2 registers: scale sum and significand product.
    logic                  s2_v;
    pclass_e               s2_cls;
    logic                  s2_sgn;
    logic signed [SCW-1:0] s2_sc;
    logic [PW-1:0]         s2_prod;

    // Add the scales and multiply the significands in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_cls  <= CLS_ZERO;
            s2_sgn  <= 1'b0;
            s2_sc   <= '0;
            s2_prod <= '0;
        end else begin
            s2_v    <= s1_v;
            s2_cls  <= s1_cls;
            s2_sgn  <= s1_sgn;
            s2_sc   <= s1_sc[0] + s1_sc[1];
            s2_prod <= s1_sig[0] * s1_sig[1];
        end
    end

    logic [N-2:0] e_body;
    logic         e_guard, e_sticky, e_hi, e_lo;

    posit_encode #(.N(N), .SCW(SCW), .PW(PW)) u_enc (
        .scale  (s2_sc),
        .prod   (s2_prod),
        .body   (e_body),
        .guard  (e_guard),
        .sticky (e_sticky),
        .sat_hi (e_hi),
        .sat_lo (e_lo)
    );

    // Stage 3 registers: truncated body and rounding information.
    logic         s3_v;
    pclass_e      s3_cls;
    logic         s3_sgn;
    logic [N-2:0] s3_body;
    logic         s3_guard, s3_sticky, s3_hi, s3_lo;

    // Hold the encoded body with its guard, sticky and saturation flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_v      <= 1'b0;
            s3_cls    <= CLS_ZERO;
            s3_sgn    <= 1'b0;
            s3_body   <= '0;
            s3_guard  <= 1'b0;
            s3_sticky <= 1'b0;
            s3_hi     <= 1'b0;
            s3_lo     <= 1'b0;
        end else begin
            s3_v      <= s2_v;
            s3_cls    <= s2_cls;
            s3_sgn    <= s2_sgn;
            s3_body   <= e_body;
            s3_guard  <= e_guard;
            s3_sticky <= e_sticky;
            s3_hi     <= e_hi;
            s3_lo     <= e_lo;
        end
    end

    logic [N-1:0] r_result;

    posit_round #(.N(N)) u_rnd (
        .body   (s3_body),
        .guard  (s3_guard),
        .sticky (s3_sticky),
        .sat_hi (s3_hi),
        .sat_lo (s3_lo),
        .cls    (s3_cls),
        .sgn    (s3_sgn),
        .result (r_result)
    );

    // Stage 4 registers: the rounded product at the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_p     <= '0;
        end else begin
            out_valid <= s3_v;
            out_p     <= r_result;
        end
    end

    // ---------------- assertions ----------------
    localparam logic [N-1:0] NAR_PAT = {1'b1, {(N - 1){1'b0}}};

    logic [2:0] since_rst;

    // Count edges since reset, up to the pipeline depth, so that $past stays in range.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= 3'd0;
        else if (since_rst != 3'd4)
            since_rst <= since_rst + 3'd1;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    assert_nar_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 3'd4) && $past(in_valid, 4) &&
         (($past(in_a, 4) == NAR_PAT) || ($past(in_b, 4) == NAR_PAT)))
        |-> (out_p == NAR_PAT));

    assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 3'd4) && $past(in_valid, 4) &&
         ($past(in_a, 4) != NAR_PAT) && ($past(in_b, 4) != NAR_PAT) &&
         (($past(in_a, 4) == '0) || ($past(in_b, 4) == '0)))
        |-> (out_p == '0));

    assert_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 3'd4) && $past(in_valid, 4) &&
         ($past(in_a[N-2:0], 4) != '0) && ($past(in_b[N-2:0], 4) != '0))
        |-> (out_p[N-1] == $past(in_a[N-1] ^ in_b[N-1], 4)));

    assert_never_vanish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 3'd4) && $past(in_valid, 4) &&
         ($past(in_a[N-2:0], 4) != '0) && ($past(in_b[N-2:0], 4) != '0))
        |-> ((out_p != '0) && (out_p != NAR_PAT)));

endmodule

// File: tb/sim_posit32_mul_pipe.sv
`timescale 1ns/1ps
module sim_posit32_mul_pipe;
    localparam logic [31:0] NAR    = 32'h8000_0000;
    localparam logic [31:0] MAXPOS = 32'h7FFF_FFFF;
    localparam logic [31:0] MINPOS = 32'h0000_0001;
    localparam int          NSTREAM = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_p;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    posit32_mul_pipe #(.N(32)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_p(out_p)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Reference decoder: reads the pattern bit by bit.
    function automatic void ref_dec(input logic [31:0] p, output int sc, output longint unsigned sig);
        logic [31:0] m;
        int r, k, pos, e;
        m = p[31] ? -p : p;
        r = 0;
        while (r < 31 && m[30 - r] == m[30]) r++;
        k = m[30] ? r - 1 : -r;
        pos = 30 - r - 1;
        e = 0;
        for (int j = 0; j < 2; j++) begin
            e = e * 2 + ((pos >= 0) ? int'(m[pos]) : 0);
            pos--;
        end
        sig = 1;
        for (int j = 0; j < 27; j++) begin
            sig = sig * 2 + ((pos >= 0) ? longint'(m[pos]) : 0);
            pos--;
        end
        sc = 4 * k + e;
    endfunction

    // Reference multiply: exact product, then the posit bit stream is emitted one bit at a time.
    function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        int sa, sb, sc, kk, ee, n;
        longint unsigned ga, gb, pr;
        logic [0:127] st;
        logic [30:0] acc;
        logic g, s;
        logic [31:0] mag;
        if (a == NAR || b == NAR) return NAR;
        if (a == 0 || b == 0) return 32'h0;
        ref_dec(a, sa, ga);
        ref_dec(b, sb, gb);
        pr = ga * gb;
        sc = sa + sb;
        if (pr[55]) sc++;
        else pr = pr << 1;
        kk = (sc >= 0) ? sc / 4 : -((-sc + 3) / 4);
        ee = sc - 4 * kk;
        if (kk >= 30) mag = MAXPOS;
        else if (kk <= -31) mag = MINPOS;
        else begin
            st = '0;
            n = 0;
            if (kk >= 0) begin
                for (int j = 0; j <= kk; j++) begin st[n] = 1'b1; n++; end
                st[n] = 1'b0; n++;
            end else begin
                for (int j = 0; j < -kk; j++) begin st[n] = 1'b0; n++; end
                st[n] = 1'b1; n++;
            end
            st[n] = ee[1]; n++;
            st[n] = ee[0]; n++;
            for (int j = 54; j >= 0; j--) begin st[n] = pr[j]; n++; end
            acc = '0;
            for (int j = 0; j < 31; j++) acc = {acc[29:0], st[j]};
            g = st[31];
            s = |st[32:127];
            mag = {1'b0, acc} + {31'b0, g & (acc[0] | s)};
        end
        return (a[31] ^ b[31]) ? -mag : mag;
    endfunction

    // One isolated multiply; called at a falling edge, result sampled four edges later.
    task automatic do_mul(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp);
        in_a = a; in_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check({req, " valid"}, {31'b0, out_valid}, 32'h1);
        check(req, out_p, exp);
    endtask

    function automatic logic [31:0] next_rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    // Random operand biased towards long regime runs and occasional specials.
    function automatic logic [31:0] rnd_operand();
        logic [31:0] x, sel;
        logic signed [30:0] t;
        x = next_rnd();
        sel = next_rnd();
        if (sel[3:0] == 4'd0) return 32'h0;
        if (sel[3:0] == 4'd1) return NAR;
        t = $signed(x[30:0]) >>> (sel[8:4] % 31);
        return {x[31], t};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b1; in_a = 32'h4800_0000; in_b = 32'h4800_0000;
        repeat (5) @(negedge clk);
        check("R10 out_valid in reset", {31'b0, out_valid}, 32'h0);
        check("R10 out_p in reset", out_p, 32'h0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_exact();
        do_mul("R5 1*1", 32'h4000_0000, 32'h4000_0000, 32'h4000_0000);
        do_mul("R5 2*3", 32'h4800_0000, 32'h4C00_0000, 32'h5400_0000);
        do_mul("R5 4*4", 32'h5000_0000, 32'h5000_0000, 32'h6000_0000);
        do_mul("R5 0.5*2", 32'h3800_0000, 32'h4800_0000, 32'h4000_0000);
        do_mul("R5 16*0.5", 32'h6000_0000, 32'h3800_0000, 32'h5800_0000);
    endtask

    task automatic t_special();
        do_mul("R2 NaR*1", NAR, 32'h4000_0000, NAR);
        do_mul("R2 1*NaR", 32'h4000_0000, NAR, NAR);
        do_mul("R2 NaR*0", NAR, 32'h0, NAR);
        do_mul("R3 0*3", 32'h0, 32'h4C00_0000, 32'h0);
        do_mul("R3 -3*0", 32'hB400_0000, 32'h0, 32'h0);
        do_mul("R3 0*0", 32'h0, 32'h0, 32'h0);
    endtask

    task automatic t_sign();
        do_mul("R4 -1*-1", 32'hC000_0000, 32'hC000_0000, 32'h4000_0000);
        do_mul("R4 -2*3", 32'hB800_0000, 32'h4C00_0000, 32'hAC00_0000);
        do_mul("R4 2*-3", 32'h4800_0000, 32'hB400_0000, 32'hAC00_0000);
        do_mul("R4 odd pattern negated", -32'h4123_4567, 32'h3ABC_DEF1,
               -ref_mul(32'h4123_4567, 32'h3ABC_DEF1));
    endtask

    task automatic t_round();
        do_mul("R6 tie rounds up to even", 32'h4000_0001, 32'h4400_0000, 32'h4400_0002);
        do_mul("R6 tie rounds down to even", 32'h4000_0003, 32'h4400_0000, 32'h4400_0004);
        do_mul("R6 below half rounds down", 32'h4000_0001, 32'h4000_0001, 32'h4000_0002);
    endtask

    task automatic t_saturate();
        do_mul("R7 maxpos*2", MAXPOS, 32'h4800_0000, MAXPOS);
        do_mul("R7 maxpos*maxpos", MAXPOS, MAXPOS, MAXPOS);
        do_mul("R7 -maxpos*2", 32'h8000_0001, 32'h4800_0000, 32'h8000_0001);
        do_mul("R8 minpos*0.5", MINPOS, 32'h3800_0000, MINPOS);
        do_mul("R8 minpos*minpos", MINPOS, MINPOS, MINPOS);
        do_mul("R8 -minpos*minpos", 32'hFFFF_FFFF, MINPOS, 32'hFFFF_FFFF);
        do_mul("R9 maxpos*minpos", MAXPOS, MINPOS, 32'h4000_0000);
        do_mul("R9 -maxpos*-minpos", 32'h8000_0001, 32'hFFFF_FFFF, 32'h4000_0000);
    endtask

    // Back-to-back stream with gaps; every output edge is compared four edges after issue.
    task automatic t_stream();
        logic        va [NSTREAM];
        logic [31:0] ea [NSTREAM];
        for (int i = 0; i < NSTREAM + 4; i++) begin
            if (i >= 4) begin
                check("R1 stream valid", {31'b0, out_valid}, {31'b0, va[i-4]});
                if (va[i-4]) check("R1 stream data", out_p, ea[i-4]);
            end
            if (i < NSTREAM) begin
                logic [31:0] a, b;
                a = rnd_operand();
                b = rnd_operand();
                va[i] = (i % 7) != 6;
                ea[i] = ref_mul(a, b);
                in_a = a; in_b = b; in_valid = va[i];
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_exact();
        t_special();
        t_sign();
        t_round();
        t_saturate();
        t_stream();
        finish_run();
    end

endmodule